// File: doc/BRIEF.md
# Binary-Search Delay Code Controller with Drift Tracking

This block drives the control code of a quantized delay line inside a delay locked loop. A phase detector compares the delayed clock with the reference clock. Each cycle it reports one early/late bit: early means the delayed clock arrives too soon, so the delay must grow. The controller first finds the matching code by binary search, resolving one code bit per accepted decision from the top bit down. Lock therefore takes as many decisions as the code has bits, not one decision per code step.

Once the lowest bit has been resolved, the controller raises a lock flag. One cycle later it changes the same code register into a saturating up/down counter. In that mode it follows slow process, voltage and temperature drift without a new search. After every accepted decision the controller waits a programmable number of cycles before it samples the next one, so the delay line has time to settle. A synchronous restart input discards the lock and begins a new search at any time.

Top module: `dll_sar_ctrl`

## Requirements
- R1: During and right after reset, the code holds only its top bit set (binary 100000 for the default 6-bit width), and both the lock flag and the tracking flag are low.
- R2: After each accepted decision, or after reset or restart, the code stays unchanged for `settleCycles` clock cycles. The next decision is taken on the following rising edge, so decisions are spaced `settleCycles`+1 cycles apart.
- R3: In search mode, a decision keeps the current trial bit at 1 when `earlyIn` is 1 and clears it when `earlyIn` is 0. The same edge sets the next lower bit to 1 as the new trial bit.
- R4: A full search takes exactly `CODE_W` decisions. When the detector reports early exactly while code <= T, the final code equals T.
- R5: The lock flag rises on the edge that resolves bit 0. The tracking flag rises one cycle later, and the lock flag stays high while the controller is tracking.
- R6: In tracking mode, each accepted decision adds 1 to the code when `earlyIn` is 1 and subtracts 1 when it is 0.
- R7: In tracking mode the code saturates: it stays at all-ones on an early decision and stays at zero on a late decision, with no wrap.
- R8: A high `restart` at a rising edge clears the lock and tracking flags and reloads the top-bit-only code, whatever the current mode. A new search then begins with the settle wait.
- R9: With `settleCycles` = 0, the controller accepts a decision on every clock edge, both in search mode and in tracking mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous request for a new search |
| earlyIn | input | 1 | Phase decision: 1 = delay must increase, 0 = delay must decrease |
| settleCycles | input | SETTLE_W | Wait, in cycles, between a code change and the next accepted decision |
| delayCode | output | CODE_W | Control code for the delay line |
| locked | output | 1 | Search has completed |
| trackMode | output | 1 | Controller is in up/down tracking mode |

## Verification
The hardest states to reach from the ports are the two saturation corners of tracking mode. They can only be reached after a complete search that settles on all-zeros or all-ones. The stimulus reaches them by imitating a phase detector whose target code is 0 or 63: it runs the whole search, waits for the switch to tracking, and then keeps pushing toward the rail. A restart in the middle of a search, and a run with no settle wait, cover the other timing paths that are hard to reach.

// File: rtl/dllc_pkg.sv
package dllc_pkg;

  // Strobes from the control FSM to the code register
  typedef struct packed {
    logic loadMsb;   // reload top-bit-only code
    logic keepBit;   // search: trial bit stays 1
    logic dropBit;   // search: trial bit cleared
    logic stepUp;    // tracking: +1
    logic stepDown;  // tracking: -1
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_LOCKED = 2'd1,
    ST_TRACK  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/dllc_datapath.sv
module dllc_datapath
  import dllc_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [IDX_W-1:0]  trialIdx,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] ALL_ONES = '1;
  localparam logic [CODE_W-1:0] ALL_ZERO = '0;

  logic [CODE_W-1:0] nextCode;

  always_comb begin
    nextCode = code;
    if (strobe.loadMsb) begin
      nextCode = MSB_ONLY;
    end else if (strobe.keepBit || strobe.dropBit) begin
      nextCode[trialIdx] = strobe.keepBit;
      if (trialIdx != '0) nextCode[trialIdx - 1'b1] = 1'b1;
    end else if (strobe.stepUp && code != ALL_ONES) begin
      nextCode = code + 1'b1;
    end else if (strobe.stepDown && code != ALL_ZERO) begin
      nextCode = code - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= MSB_ONLY;
    else       code <= nextCode;
  end

  // R7
  no_wrap_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code == ALL_ONES && strobe.stepUp && !strobe.loadMsb) |=> code == ALL_ONES);

  // R7
  no_wrap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (code == ALL_ZERO && strobe.stepDown && !strobe.loadMsb) |=> code == ALL_ZERO);

endmodule

// File: rtl/dllc_ctrl.sv
module dllc_ctrl
  import dllc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restart,
  input  logic                earlyIn,
  input  logic [SETTLE_W-1:0] settleCycles,
  output dpStrobe_t           strobe,
  output logic [IDX_W-1:0]    trialIdx,
  output logic                locked,
  output logic                trackMode
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);

  ctlState_t           stateQ;
  logic [SETTLE_W-1:0] waitCnt;
  logic                ready;
  logic                decStrobe;

  assign ready     = (waitCnt >= settleCycles);
  assign decStrobe = strobe.keepBit | strobe.dropBit | strobe.stepUp | strobe.stepDown;

  always_comb begin
    strobe = '0;
    if (restart) begin
      strobe.loadMsb = 1'b1;
    end else if (ready) begin
      case (stateQ)
        ST_SEARCH: begin
          strobe.keepBit = earlyIn;
          strobe.dropBit = !earlyIn;
        end
        ST_TRACK: begin
          strobe.stepUp   = earlyIn;
          strobe.stepDown = !earlyIn;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_SEARCH;
      waitCnt   <= '0;
      trialIdx  <= TOP_IDX;
      locked    <= 1'b0;
      trackMode <= 1'b0;
    end else if (restart) begin
      stateQ    <= ST_SEARCH;
      waitCnt   <= '0;
      trialIdx  <= TOP_IDX;
      locked    <= 1'b0;
      trackMode <= 1'b0;
    end else begin
      case (stateQ)
        ST_SEARCH: begin
          if (ready) begin
            waitCnt <= '0;
            if (trialIdx == '0) begin
              locked <= 1'b1;
              stateQ <= ST_LOCKED;
            end else begin
              trialIdx <= trialIdx - 1'b1;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_LOCKED: begin
          stateQ    <= ST_TRACK;
          trackMode <= 1'b1;
          waitCnt   <= '0;
        end
        default: begin
          if (ready) waitCnt <= '0;
          else       waitCnt <= waitCnt + 1'b1;
        end
      endcase
    end
  end

  // R5
  track_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trackMode) |-> (locked && $past(locked)));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!locked && !trackMode && stateQ == ST_SEARCH));

  // R2
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decStrobe && !restart) |=> (settleCycles == '0 || !decStrobe));

endmodule

// File: rtl/dll_sar_ctrl.sv
module dll_sar_ctrl
  import dllc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restart,
  input  logic                earlyIn,
  input  logic [SETTLE_W-1:0] settleCycles,
  output logic [CODE_W-1:0]   delayCode,
  output logic                locked,
  output logic                trackMode
);

  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  dpStrobe_t        strobe;
  logic [IDX_W-1:0] trialIdx;

  dllc_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .earlyIn(earlyIn),
    .settleCycles(settleCycles), .strobe(strobe), .trialIdx(trialIdx),
    .locked(locked), .trackMode(trackMode)
  );

  dllc_datapath #(.CODE_W(CODE_W), .IDX_W(IDX_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trialIdx(trialIdx),
    .code(delayCode)
  );

  // R6
  track_unit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trackMode && !restart) |=> (delayCode == $past(delayCode)
                                 || delayCode == $past(delayCode) + 1
                                 || delayCode == $past(delayCode) - 1));

endmodule

// File: tb/test_dll_sar_ctrl.sv
module test_dll_sar_ctrl;

  localparam int CLK_P = 10;
  localparam int W     = 6;
  localparam int SW    = 4;

  typedef struct {
    logic [W-1:0] code;
    logic         lock;
    logic         track;
    string        req;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          restart = 1'b0;
  logic          earlyIn = 1'b0;
  logic [SW-1:0] settleCycles = SW'(4);
  logic [W-1:0]  delayCode;
  logic          locked;
  logic          trackMode;

  int errors = 0;
  int checks = 0;
  expItem_t expQ[$];

  logic [W-1:0] expCode;
  int           expIdx;
  logic         expLock;
  logic         expTrack;
  int           settleVal = 4;

  always #(CLK_P/2) clk = ~clk;

  dll_sar_ctrl #(.CODE_W(W), .SETTLE_W(SW)) i_dll_sar_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart), .earlyIn(earlyIn),
    .settleCycles(settleCycles), .delayCode(delayCode),
    .locked(locked), .trackMode(trackMode)
  );

  // Monitor: compares queued expectations a quarter period after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (delayCode !== it.code || locked !== it.lock || trackMode !== it.track) begin
          errors++;
          $display("FAIL %s: got code=%0d lock=%0b track=%0b, expected code=%0d lock=%0b track=%0b",
                   it.req, delayCode, locked, trackMode, it.code, it.lock, it.track);
        end
      end
    end
  end

  task automatic pushExp(input string req);
    expItem_t it;
    it.code = expCode; it.lock = expLock; it.track = expTrack; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic modelReset();
    expCode  = {1'b1, {(W-1){1'b0}}};
    expIdx   = W - 1;
    expLock  = 1'b0;
    expTrack = 1'b0;
  endtask

  // One accepted decision; starts and ends at a falling edge
  task automatic decide(input logic early, input string req);
    earlyIn = early;
    if (settleVal > 0) begin
      repeat (settleVal) @(posedge clk);
      @(negedge clk);
      pushExp("R2 hold during settle");
    end
    @(posedge clk);
    @(negedge clk);
    if (!expTrack) begin
      expCode[expIdx] = early;
      if (expIdx > 0) begin
        expCode[expIdx-1] = 1'b1;
        expIdx--;
      end else begin
        expLock = 1'b1;
      end
    end else if (early) begin
      if (expCode != '1) expCode = expCode + 1'b1;
    end else begin
      if (expCode != '0) expCode = expCode - 1'b1;
    end
    pushExp(req);
  endtask

  task automatic searchTo(input logic [W-1:0] target, input string req);
    for (int i = 0; i < W; i++) begin
      decide(expCode <= target, (i == W-1) ? req : "R3 search step");
    end
    if (expCode !== target) begin
      errors++;
      $display("FAIL R4 model: got %0d expected %0d", expCode, target);
    end
  endtask

  task automatic enterTrack();
    @(posedge clk);
    @(negedge clk);
    expTrack = 1'b1;
    pushExp("R5 tracking one cycle after lock");
  endtask

  task automatic restartPulse(input int newSettle);
    restart = 1'b1;
    settleVal = newSettle;
    settleCycles = SW'(newSettle);
    @(posedge clk);
    @(negedge clk);
    restart = 1'b0;
    modelReset();
    pushExp("R8 restart");
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    pushExp("R1 reset state");
    @(negedge clk);
    pushExp("R1 reset state");
    rstN = 1'b1;

    // Search to 45, lock flag on the LSB edge
    searchTo(6'd45, "R4 R5 lock at target 45");
    enterTrack();
    // R6 tracking steps
    decide(1'b1, "R6 track up");
    decide(1'b1, "R6 track up");
    decide(1'b0, "R6 track down");
    decide(1'b0, "R6 track down");
    decide(1'b0, "R6 track down");

    // R8 restart from tracking, then search to 0 and saturate low
    restartPulse(4);
    searchTo(6'd0, "R4 lock at 0");
    enterTrack();
    decide(1'b0, "R7 saturate low");
    decide(1'b0, "R7 saturate low");
    decide(1'b1, "R6 up from zero");

    // Saturate high with a shorter settle wait
    restartPulse(2);
    searchTo(6'd63, "R4 lock at 63");
    enterTrack();
    decide(1'b1, "R7 saturate high");
    decide(1'b0, "R6 down from top");

    // R9 no settle wait
    restartPulse(0);
    searchTo(6'd21, "R9 R4 lock at 21 without wait");
    enterTrack();
    decide(1'b1, "R9 track every cycle");
    decide(1'b1, "R9 track every cycle");

    // Restart in the middle of a search
    restartPulse(4);
    decide(1'b0, "R3 search step");
    decide(1'b1, "R3 search step");
    restartPulse(4);
    searchTo(6'd10, "R8 R4 fresh search after abort");
    enterTrack();

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule